// File: doc/BRIEF.md
# Rotation and Extended Telemetry Interpreter

This block receives the 12-bit value carried back by a motor controller reply, once the line decoding and the checksum test are done. It decides whether that value reports a rotation period or one of the extended status quantities. For a rotation period it works out the electrical RPM with a rounded integer division. For an extended quantity it passes the raw field on, with a type tag. The consumer applies any unit scaling, such as the quarter-volt step of a voltage report.

Every valid rotation result is kept in a small per-channel table. It also sets that channel's bit in an update mask, so that a controller can find out which channels have fresh speed data since it last looked. The mask is read and cleared in one cycle. Payloads that need no division give their result straight after the accepting edge. A rotation period goes through a sequential divider and keeps the block busy until the result appears.

Top module: `erpm_telem_interp`

## Requirements
- R1: The payload splits into a 3-bit exponent in bits [11:9] and a 9-bit mantissa in bits [8:0]. Every result carries the mantissa of its payload on `res_value`.
- R2: With `ext_en` high, mantissa bit 8 low and an exponent of 1 to 7, the result is an extended report, visible right after the accepting edge. Its `res_kind` equals the exponent: 1 temperature in degrees C, 2 voltage in 0.25 V steps, 3 current in amperes, 4 and 5 debug, 6 stress level, 7 status. It has `res_erpm_ok` = 0 and `res_erpm` = 0xFFFF, and it leaves the mask and the table unchanged.
- R3: Every other payload is a rotation report with `res_kind` = 0. Its period is the mantissa shifted left by the exponent, truncated to 16 bits.
- R4: For a nonzero period, `res_erpm` = floor((600000 + floor(period/2)) / period). The result appears 21 cycles after the accepting edge.
- R5: A zero period gives, right after the accepting edge, `res_kind` = 0, `res_erpm_ok` = 0 and `res_erpm` = 0xFFFF.
- R6: The payload 0xFFF is the zero-speed code, whatever the state of `ext_en`. Right after the accepting edge it gives `res_erpm` = 0 with `res_erpm_ok` = 1.
- R7: A quotient of 0xFFFF or more is invalid: `res_erpm_ok` = 0, `res_erpm` = 0xFFFF, and nothing is stored.
- R8: A valid rotation result writes its eRPM into the table entry for the channel given with the payload, where `sel_erpm` shows it for `sel_chan`. At the same edge it sets that channel's bit in `upd_mask`.
- R9: An edge with `mask_rd` high clears `upd_mask`. A bit set by a result at the same edge stays set.
- R10: `busy` is high from the edge that accepts a dividing payload up to the edge that presents its result. `pl_valid` is ignored while `busy` is high.
- R11: After reset `busy`, `res_valid`, `res_erpm_ok` and `upd_mask` are 0, and every table entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pl_valid | input | 1 | Payload strobe |
| pl_data | input | 12 | Exponent and mantissa payload |
| pl_chan | input | 2 | Channel the payload belongs to |
| ext_en | input | 1 | Allows extended report types |
| busy | output | 1 | Division in progress; new payloads are ignored |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 3 | 0 rotation, 1 to 7 extended type |
| res_value | output | 9 | Raw mantissa of the result |
| res_erpm | output | 16 | eRPM, 0xFFFF when not valid |
| res_erpm_ok | output | 1 | eRPM valid |
| mask_rd | input | 1 | Read-and-clear strobe for the update mask |
| upd_mask | output | 4 | Per-channel fresh-data mask |
| sel_chan | input | 2 | Table read index |
| sel_erpm | output | 16 | Stored eRPM of `sel_chan` |

## Verification
The payloads are chosen to separate the three ways a value is routed. The same exponent and mantissa are sent with `ext_en` high and low, and then with mantissa bit 8 set, so that a wrong classification shows up as a tag or latency mismatch. Periods of 9 and 10 sit on either side of the 0xFFFF validity limit, and zero periods and the all-ones code check the immediate paths. A largely random stream then mixes payloads during busy windows, back-to-back immediate results, and mask reads that fall on the very edge of a result.

// File: rtl/erpm_pkg.sv
package erpm_pkg;

   // report tag; for extended reports it equals the payload exponent
   typedef enum logic [2:0] {
      KIND_ROT    = 3'd0,
      KIND_TEMP   = 3'd1,
      KIND_VOLT   = 3'd2,
      KIND_CURR   = 3'd3,
      KIND_DBG_A  = 3'd4,
      KIND_DBG_B  = 3'd5,
      KIND_STRESS = 3'd6,
      KIND_STATUS = 3'd7
   } telem_kind_e;

endpackage

// File: rtl/erpm_classify.sv
module erpm_classify #(
   parameter int EXP_W    = 3,
   parameter int MANT_W   = 9,
   parameter int PERIOD_W = 16
) (
   input  logic [EXP_W+MANT_W-1:0] payload,
   input  logic                    ext_en,
   output logic [EXP_W-1:0]        expo,
   output logic [MANT_W-1:0]       mant,
   output logic                    is_ext,
   output logic                    is_zero_code,
   output logic [PERIOD_W-1:0]     period,
   output logic                    period_zero
);
   localparam int PAYLOAD_W = EXP_W + MANT_W;
   localparam int WIDE_W    = MANT_W + (1 << EXP_W) - 1;

   logic [WIDE_W-1:0] shifted;

   assign expo         = payload[PAYLOAD_W-1 -: EXP_W];
   assign mant         = payload[MANT_W-1:0];
   assign is_zero_code = &payload;
   assign is_ext       = ext_en && !mant[MANT_W-1] && (expo != '0);
   assign shifted      = WIDE_W'(mant) << expo;

   generate
      if (WIDE_W >= PERIOD_W) begin : g_trunc
         assign period = shifted[PERIOD_W-1:0];
      end else begin : g_extend
         assign period = PERIOD_W'(shifted);
      end
   endgenerate

   assign period_zero = (period == '0);

endmodule

// File: rtl/erpm_divider.sv
module erpm_divider #(
   parameter int NUM_W = 20,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] numer,
   input  logic [DEN_W-1:0] denom,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quot
);
   localparam int CNT_W = $clog2(NUM_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DEN_W:0]   rem_sh;
   logic [DEN_W:0]   rem_sub;
   logic             fits;

   always_comb begin
      rem_sh  = {rem_q, quo_q[NUM_W-1]};
      fits    = (rem_sh >= {1'b0, den_q});
      rem_sub = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            quo_q <= numer;
            rem_q <= '0;
            den_q <= denom;
            cnt_q <= '0;
            busy  <= 1'b1;
         end else if (busy) begin
            rem_q <= rem_sub[DEN_W-1:0];
            quo_q <= {quo_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quot = quo_q;

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

endmodule

// File: rtl/erpm_chan_store.sv
module erpm_chan_store #(
   parameter int NUM_CH = 4,
   parameter int VAL_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [CH_W-1:0]       wr_chan,
   input  logic [VAL_W-1:0]      wr_val,
   input  logic                  clr,
   input  logic [CH_W-1:0]       rd_chan,
   output logic [VAL_W-1:0]      rd_val,
   output logic [NUM_CH-1:0]     mask
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic [VAL_W-1:0] vals [NUM_CH];

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic hit;
         assign hit = wr_en && (wr_chan == CH_W'(ch));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vals[ch] <= '0;
               mask[ch] <= 1'b0;
            end else begin
               if (hit) begin
                  vals[ch] <= wr_val;
               end
               if (hit) begin
                  mask[ch] <= 1'b1;
               end else if (clr) begin
                  mask[ch] <= 1'b0;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_chan == CH_W'(i)) rd_val = vals[i];
      end
   end

   // R9
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en) |=> (mask == '0));

   // R8
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_chan) < NUM_CH)) |=> mask[$past(wr_chan)]);

endmodule

// File: rtl/erpm_telem_interp.sv
module erpm_telem_interp
   import erpm_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int EXP_W      = 3,
   parameter int MANT_W     = 9,
   parameter int PERIOD_W   = 16,
   parameter int ERPM_W     = 16,
   parameter int ERPM_NUMER = 600000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pl_valid,
   input  logic [EXP_W+MANT_W-1:0]       pl_data,
   input  logic [CH_W-1:0]               pl_chan,
   input  logic                          ext_en,
   output logic                          busy,
   output logic                          res_valid,
   output logic [EXP_W-1:0]              res_kind,
   output logic [MANT_W-1:0]             res_value,
   output logic [ERPM_W-1:0]             res_erpm,
   output logic                          res_erpm_ok,
   input  logic                          mask_rd,
   output logic [NUM_CH-1:0]             upd_mask,
   input  logic [CH_W-1:0]               sel_chan,
   output logic [ERPM_W-1:0]             sel_erpm
);
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int NUM_MAX = ERPM_NUMER + (1 << (PERIOD_W - 1));
   localparam int NUM_W   = $clog2(NUM_MAX + 1);
   localparam logic [ERPM_W-1:0] ERPM_BAD = {ERPM_W{1'b1}};

   generate
      if (EXP_W != 3) begin : g_bad_exp
         $error("report tag needs a 3-bit exponent");
      end
      if (NUM_W <= ERPM_W) begin : g_bad_num
         $error("numerator narrower than the eRPM field");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("at least one channel required");
      end
   endgenerate

   logic [EXP_W-1:0]    c_expo;
   logic [MANT_W-1:0]   c_mant;
   logic                c_ext;
   logic                c_zero_code;
   logic [PERIOD_W-1:0] c_period;
   logic                c_period_zero;

   erpm_classify #(
      .EXP_W(EXP_W), .MANT_W(MANT_W), .PERIOD_W(PERIOD_W)
   ) u_cls (
      .payload(pl_data), .ext_en(ext_en),
      .expo(c_expo), .mant(c_mant), .is_ext(c_ext),
      .is_zero_code(c_zero_code), .period(c_period),
      .period_zero(c_period_zero)
   );

   logic             accept;
   logic             need_div;
   logic             div_start;
   logic             div_busy;
   logic             div_done;
   logic [NUM_W-1:0] div_num;
   logic [NUM_W-1:0] div_quot;
   logic             q_fits;

   assign accept    = pl_valid && !busy;
   assign need_div  = !c_ext && !c_zero_code && !c_period_zero;
   assign div_start = accept && need_div;
   assign div_num   = NUM_W'(ERPM_NUMER) + NUM_W'(c_period >> 1);

   erpm_divider #(.NUM_W(NUM_W), .DEN_W(PERIOD_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start),
      .numer(div_num), .denom(c_period),
      .busy(div_busy), .done(div_done), .quot(div_quot)
   );

   assign busy   = div_busy | div_done;
   assign q_fits = (div_quot < NUM_W'(ERPM_BAD));

   // context held across the division
   logic [CH_W-1:0]   ctx_chan;
   logic [MANT_W-1:0] ctx_mant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_chan <= '0;
         ctx_mant <= '0;
      end else if (div_start) begin
         ctx_chan <= pl_chan;
         ctx_mant <= c_mant;
      end
   end

   // result registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_kind    <= '0;
         res_value   <= '0;
         res_erpm    <= ERPM_BAD;
         res_erpm_ok <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (div_done) begin
            res_valid   <= 1'b1;
            res_kind    <= KIND_ROT;
            res_value   <= ctx_mant;
            res_erpm_ok <= q_fits;
            res_erpm    <= q_fits ? div_quot[ERPM_W-1:0] : ERPM_BAD;
         end else if (accept && !need_div) begin
            res_valid   <= 1'b1;
            res_kind    <= c_ext ? c_expo : KIND_ROT;
            res_value   <= c_mant;
            res_erpm_ok <= c_zero_code;
            res_erpm    <= c_zero_code ? '0 : ERPM_BAD;
         end
      end
   end

   logic              st_wr;
   logic [CH_W-1:0]   st_chan;
   logic [ERPM_W-1:0] st_val;

   assign st_wr   = (div_done && q_fits) || (accept && !need_div && c_zero_code);
   assign st_chan = div_done ? ctx_chan : pl_chan;
   assign st_val  = div_done ? div_quot[ERPM_W-1:0] : '0;

   erpm_chan_store #(.NUM_CH(NUM_CH), .VAL_W(ERPM_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(st_wr), .wr_chan(st_chan), .wr_val(st_val),
      .clr(mask_rd), .rd_chan(sel_chan), .rd_val(sel_erpm),
      .mask(upd_mask)
   );

   // R7
   erpm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_erpm_ok) |-> (res_erpm != ERPM_BAD));

   // R2
   ext_no_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_kind != KIND_ROT)) |-> !res_erpm_ok);

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !div_done) |=> !(res_valid && (res_kind != KIND_ROT)));

   // R5
   zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !c_ext && c_period_zero) |=> (res_valid && !res_erpm_ok));

endmodule

// File: tb/erpm_telem_interp_test.sv
module erpm_telem_interp_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int DIV_LAT    = 21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pl_valid = 1'b0;
   logic [11:0] pl_data = '0;
   logic [1:0]  pl_chan = '0;
   logic        ext_en = 1'b0;
   logic        mask_rd = 1'b0;
   logic [1:0]  sel_chan = '0;
   logic        busy;
   logic        res_valid;
   logic [2:0]  res_kind;
   logic [8:0]  res_value;
   logic [15:0] res_erpm;
   logic        res_erpm_ok;
   logic [3:0]  upd_mask;
   logic [15:0] sel_erpm;

   erpm_telem_interp uut (
      .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_data(pl_data),
      .pl_chan(pl_chan), .ext_en(ext_en), .busy(busy), .res_valid(res_valid),
      .res_kind(res_kind), .res_value(res_value), .res_erpm(res_erpm),
      .res_erpm_ok(res_erpm_ok), .mask_rd(mask_rd), .upd_mask(upd_mask),
      .sel_chan(sel_chan), .sel_erpm(sel_erpm)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   string cur_req = "R11";

   // reference model state
   int m_wait = 0;
   int m_rv = 0, m_kind = 0, m_val = 0, m_erpm = 65535, m_ok = 0;
   int m_mask = 0;
   int m_store [NCH];
   int p_q = 0, p_ch = 0, p_mant = 0;

   task automatic chk(input bit good, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!good) begin
         bad++;
         $display("FAIL %s (%s) %s: actual=%0d expected=%0d", req, cur_req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wait = 0; m_rv = 0; m_kind = 0; m_val = 0; m_erpm = 65535; m_ok = 0;
         m_mask = 0;
         for (int i = 0; i < NCH; i++) m_store[i] = 0;
      end else begin
         automatic bit busy_pre = (m_wait > 0);
         m_rv = 0;
         if (mask_rd) m_mask = 0;
         if (m_wait > 0) begin
            m_wait--;
            if (m_wait == 0) begin
               m_rv = 1; m_kind = 0; m_val = p_mant;
               m_ok = (p_q < 65535);
               m_erpm = m_ok ? p_q : 65535;
               if (m_ok) begin
                  m_store[p_ch] = p_q;
                  m_mask |= (1 << p_ch);
               end
            end
         end
         if (pl_valid && !busy_pre) begin
            automatic int e = int'(pl_data) >> 9;
            automatic int m = int'(pl_data) & 511;
            automatic int p = (m << e) & 65535;
            if (pl_data == 12'hFFF) begin
               m_rv = 1; m_kind = 0; m_val = m; m_ok = 1; m_erpm = 0;
               m_store[pl_chan] = 0;
               m_mask |= (1 << pl_chan);
            end else if (ext_en && m < 256 && e != 0) begin
               m_rv = 1; m_kind = e; m_val = m; m_ok = 0; m_erpm = 65535;
            end else if (p == 0) begin
               m_rv = 1; m_kind = 0; m_val = m; m_ok = 0; m_erpm = 65535;
            end else begin
               m_wait = DIV_LAT;
               p_q = (600000 + p / 2) / p;
               p_ch = int'(pl_chan);
               p_mant = m;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == (m_wait > 0), "R10", "busy", busy, m_wait > 0);
         chk(res_valid == m_rv, "R4", "res_valid", res_valid, m_rv);
         if (res_valid && m_rv) begin
            chk(res_kind == m_kind, "R2", "res_kind", res_kind, m_kind);
            chk(res_value == m_val, "R1", "res_value", res_value, m_val);
            chk(res_erpm_ok == m_ok, "R7", "res_erpm_ok", res_erpm_ok, m_ok);
            chk(res_erpm == m_erpm, "R4", "res_erpm", res_erpm, m_erpm);
         end
         chk(upd_mask == m_mask, "R9", "upd_mask", upd_mask, m_mask);
         chk(sel_erpm == m_store[sel_chan], "R8", "sel_erpm", sel_erpm, m_store[sel_chan]);
      end
   end

   task automatic send(input int data, input int ch, input bit ext);
      @(posedge clk); #1;
      pl_valid = 1'b1; pl_data = 12'(data); pl_chan = 2'(ch); ext_en = ext;
      sel_chan = 2'(ch);
      @(posedge clk); #1;
      pl_valid = 1'b0;
      while (busy) begin @(posedge clk); #1; end
   endtask

   function automatic int pl(input int e, input int m);
      return (e << 9) | m;
   endfunction

   int cyc = 0;
   bit wd_hit = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !wd_hit) begin
         wd_hit = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk(busy == 1'b0, "R11", "busy", busy, 0);
      chk(res_valid == 1'b0, "R11", "res_valid", res_valid, 0);
      chk(res_erpm_ok == 1'b0, "R11", "res_erpm_ok", res_erpm_ok, 0);
      chk(upd_mask == '0, "R11", "upd_mask", upd_mask, 0);
      chk(sel_erpm == '0, "R11", "sel_erpm", sel_erpm, 0);
      rst_n = 1'b1;

      // R2 extended types, each exponent
      cur_req = "R2";
      for (int e = 1; e < 8; e++) send(pl(e, 9'h025 + e), e % NCH, 1'b1);
      // R3 same payload with extended mode off -> rotation
      cur_req = "R3";
      send(pl(2, 9'h0A0), 1, 1'b0);
      // R3 mantissa top bit set overrides extended
      send(pl(3, 9'h150), 2, 1'b1);
      // R3 exponent 0 with extended on
      send(pl(0, 9'h0C8), 3, 1'b1);
      // R4 largest period
      cur_req = "R4";
      send(pl(7, 9'h100), 0, 1'b0);
      send(pl(7, 9'h1FE), 1, 1'b1);
      // R7 limit around 0xFFFF
      cur_req = "R7";
      send(pl(0, 10), 2, 1'b0);
      send(pl(0, 9), 3, 1'b0);
      send(pl(0, 1), 3, 1'b0);
      // R5 zero period
      cur_req = "R5";
      send(pl(0, 0), 0, 1'b0);
      send(pl(6, 0), 1, 1'b0);
      // R6 zero-speed code with extended on and off
      cur_req = "R6";
      send(12'hFFF, 2, 1'b1);
      send(12'hFFF, 1, 1'b0);

      // R9 mask read, then read colliding with a result edge
      cur_req = "R9";
      @(posedge clk); #1 mask_rd = 1'b1;
      @(posedge clk); #1 mask_rd = 1'b0;
      @(posedge clk); #1;
      pl_valid = 1'b1; pl_data = 12'(pl(4, 9'h140)); pl_chan = 2'd3; ext_en = 1'b0;
      @(posedge clk); #1 pl_valid = 1'b0; mask_rd = 1'b1;
      repeat (25) @(posedge clk);
      #1 mask_rd = 1'b0;

      // R10 payloads offered during busy are dropped
      cur_req = "R10";
      @(posedge clk); #1;
      pl_valid = 1'b1; pl_data = 12'(pl(1, 9'h180)); pl_chan = 2'd0; ext_en = 1'b1;
      @(posedge clk); #1;
      pl_data = 12'(pl(5, 9'h011));
      repeat (8) @(posedge clk);
      #1 pl_data = 12'hFFF; pl_chan = 2'd2;
      repeat (4) @(posedge clk);
      #1 pl_valid = 1'b0;
      while (busy) begin @(posedge clk); #1; end

      // R2 back-to-back immediate results
      cur_req = "R2";
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); #1;
         pl_valid = 1'b1; pl_data = 12'(pl(1 + i, 9'h033 + i)); ext_en = 1'b1;
      end
      @(posedge clk); #1 pl_valid = 1'b0;

      // R8 mixed random stream
      cur_req = "R8";
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk); #1;
         pl_valid = ($urandom_range(0, 3) == 0);
         pl_data  = ($urandom_range(0, 15) == 0) ? 12'hFFF : 12'($urandom);
         pl_chan  = 2'($urandom);
         ext_en   = 1'($urandom);
         mask_rd  = ($urandom_range(0, 7) == 0);
         sel_chan = 2'($urandom);
      end
      @(posedge clk); #1;
      pl_valid = 1'b0; mask_rd = 1'b0;
      repeat (30) @(posedge clk);
      #1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule